// File: doc/BRIEF.md
# Bit-Sliced Ripple-Carry ALU

This block is a purely combinational arithmetic logic unit for a 32-bit integer datapath. It takes two operands and a 3-bit operation code. It returns a result word, a flag that is set when that result is all zeros, a carry out of the top bit, and a signed overflow flag. The zero flag is meant for equality branches: subtract the two operands and test the flag.

The unit is built from identical one-bit slices, one for each operand bit. Each slice contains a full adder, a conditional inverter on its second operand bit and a small output selector. Carries ripple from bit 0 upward. The most significant bit of the operation code does two things: it inverts the second operand in every slice, and it forces the carry into bit 0. Subtraction is therefore the same adder with a different carry-in. The set-on-less-than bit is taken from the difference after a correction for signed overflow, and it is routed back into the selector of bit 0.

Top module: `alu_core`

## Requirements
- R1: Code 000 gives `result_o = a_i & b_i`, bit by bit.
- R2: Code 001 gives `result_o = a_i | b_i`, bit by bit.
- R3: Code 010 gives the low 32 bits of `a_i + b_i` on `result_o`, and the 33rd bit of that unsigned sum on `carry_o`.
- R4: Code 110 gives `a_i - b_i` in two's complement on `result_o`.
- R5: Code 111 drives `result_o` bit 0 to 1 when `a_i` is less than `b_i` as signed numbers and to 0 otherwise. Bits 31..1 are always 0. The answer stays correct when the internal difference overflows.
- R6: `zero_o` is 1 exactly when all 32 bits of `result_o` are 0, whatever the code.
- R7: For code 010, `overflow_o` is 1 exactly when both operands have the same sign and the sign of the sum differs from it. For codes 110 and 111, `overflow_o` is 1 exactly when the operand signs differ and the sign of the difference differs from the sign of `a_i`.
- R8: Codes 011, 100 and 101 give an all-zero `result_o`, so `zero_o` reads 1.
- R9: For codes 110 and 111, `carry_o` is 1 exactly when `a_i >= b_i` as unsigned numbers, which means no borrow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| op_i | input | 3 | Operation code |
| result_o | output | 32 | Selected result word |
| zero_o | output | 1 | High when result_o is all zeros |
| carry_o | output | 1 | Carry out of the most significant slice |
| overflow_o | output | 1 | Signed overflow of the adder |

## Verification
The assertions take for granted that the operands and the operation code are fully known, with no X or Z bits. They are skipped whenever any input bit is unknown. The bench sets all three inputs in the same step, half a clock before it samples the outputs. Every value comes either from a named constant (the most negative value, the most positive value, all ones, equal pairs) or from a seeded random generator, so no unknown bit ever reaches the unit.

// File: rtl/alu_core_pkg.sv
package alu_core_pkg;

    typedef enum logic [2:0] {
        OP_AND = 3'b000,
        OP_OR  = 3'b001,
        OP_ADD = 3'b010,
        OP_SUB = 3'b110,
        OP_SLT = 3'b111
    } alu_op_e;

    typedef enum logic [1:0] {
        SEL_AND  = 2'b00,
        SEL_OR   = 2'b01,
        SEL_SUM  = 2'b10,
        SEL_LESS = 2'b11
    } slice_sel_e;

    typedef struct packed {
        logic       invert_b;
        logic       carry_in;
        slice_sel_e sel;
        logic       valid;
    } slice_ctrl_t;

    // The top code bit controls negation; the low two bits pick the slice output.
    function automatic slice_ctrl_t decode_op(input logic [2:0] op);
        slice_ctrl_t c;
        c.invert_b = op[2];
        c.carry_in = op[2];
        c.sel      = slice_sel_e'(op[1:0]);
        case (op)
            OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT: c.valid = 1'b1;
            default:                               c.valid = 1'b0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
    import alu_core_pkg::*;
(
    input  logic       a,
    input  logic       b,
    input  logic       cin,
    input  logic       less,
    input  logic       invert_b,
    input  slice_sel_e sel,
    input  logic       valid,
    output logic       res,
    output logic       sum,
    output logic       cout
);
    logic b_eff;

    always_comb begin
        b_eff = b ^ invert_b;
        sum   = a ^ b_eff ^ cin;
        cout  = (a & b_eff) | (a & cin) | (b_eff & cin);
    end

    always_comb begin
        if (!valid) begin
            res = 1'b0;
        end else begin
            case (sel)
                SEL_AND:  res = a & b;
                SEL_OR:   res = a | b;
                SEL_SUM:  res = sum;
                SEL_LESS: res = less;
                default:  res = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/alu_slice_array.sv
module alu_slice_array
    import alu_core_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  slice_ctrl_t      ctrl,
    input  logic             less_in,
    output logic [WIDTH-1:0] result,
    output logic [WIDTH-1:0] sum,
    output logic [WIDTH:0]   carry
);
    assign carry[0] = ctrl.carry_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        logic less_bit;
        if (i == 0) begin : g_lsb
            assign less_bit = less_in;
        end else begin : g_upper
            assign less_bit = 1'b0;
        end

        alu_bit_slice u_slice (
            .a        (a[i]),
            .b        (b[i]),
            .cin      (carry[i]),
            .less     (less_bit),
            .invert_b (ctrl.invert_b),
            .sel      (ctrl.sel),
            .valid    (ctrl.valid),
            .res      (result[i]),
            .sum      (sum[i]),
            .cout     (carry[i+1])
        );
    end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] result,
    input  logic             sum_msb,
    input  logic             carry_into_msb,
    input  logic             carry_out_msb,
    output logic             zero,
    output logic             overflow,
    output logic             set_less
);
    always_comb begin
        overflow = carry_into_msb ^ carry_out_msb;
        set_less = sum_msb ^ overflow;
        zero     = ~|result;
    end
endmodule

// File: rtl/alu_core.sv
module alu_core
    import alu_core_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [2:0]       op_i,
    output logic [WIDTH-1:0] result_o,
    output logic             zero_o,
    output logic             carry_o,
    output logic             overflow_o
);
    localparam int MSB = WIDTH - 1;

    slice_ctrl_t      ctrl;
    logic [WIDTH-1:0] sum_w;
    logic [WIDTH:0]   carry_w;
    logic             set_less_w;

    assign ctrl = decode_op(op_i);

    alu_slice_array #(.WIDTH(WIDTH)) u_array (
        .a       (a_i),
        .b       (b_i),
        .ctrl    (ctrl),
        .less_in (set_less_w),
        .result  (result_o),
        .sum     (sum_w),
        .carry   (carry_w)
    );

    alu_flag_unit #(.WIDTH(WIDTH)) u_flags (
        .result         (result_o),
        .sum_msb        (sum_w[MSB]),
        .carry_into_msb (carry_w[MSB]),
        .carry_out_msb  (carry_w[WIDTH]),
        .zero           (zero_o),
        .overflow       (overflow_o),
        .set_less       (set_less_w)
    );

    assign carry_o = carry_w[WIDTH];
endmodule

// File: rtl/alu_core_chk.sv
module alu_core_chk #(
    parameter int WIDTH = 32
) (
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [2:0]       op_i,
    input logic [WIDTH-1:0] result_o,
    input logic             zero_o,
    input logic             carry_o,
    input logic             overflow_o
);
    always_comb begin
        logic [WIDTH:0] add_ref;
        add_ref = {1'b0, a_i} + {1'b0, b_i};
        if (!$isunknown({a_i, b_i, op_i})) begin
            if (op_i == 3'b000)
                a_r1_and_bits: assert (result_o == (a_i & b_i));
            if (op_i == 3'b010)
                a_r3_add_carry: assert ({carry_o, result_o} == add_ref);
            if (op_i == 3'b110)
                a_r4_sub_value: assert (result_o == a_i - b_i);
            if (op_i == 3'b111)
                a_r5_slt_upper_clear: assert (result_o[WIDTH-1:1] == '0);
            a_r6_zero_flag: assert (zero_o == (result_o == '0));
            if (op_i == 3'b010)
                a_r7_add_overflow: assert (overflow_o ==
                    ((a_i[WIDTH-1] == b_i[WIDTH-1]) && (add_ref[WIDTH-1] != a_i[WIDTH-1])));
            if (op_i == 3'b011 || op_i == 3'b100 || op_i == 3'b101)
                a_r8_undefined_zero: assert (result_o == '0 && zero_o);
        end
    end
endmodule

bind alu_core alu_core_chk #(.WIDTH(WIDTH)) u_alu_core_chk (
    .a_i        (a_i),
    .b_i        (b_i),
    .op_i       (op_i),
    .result_o   (result_o),
    .zero_o     (zero_o),
    .carry_o    (carry_o),
    .overflow_o (overflow_o)
);

// File: tb/test_alu_core.sv
module test_alu_core;
    localparam int W = 32;
    localparam logic [W-1:0] MOST_NEG = 32'h8000_0000;
    localparam logic [W-1:0] MOST_POS = 32'h7FFF_FFFF;
    localparam logic [W-1:0] ALL_ONES = 32'hFFFF_FFFF;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] a, b, result;
    logic [2:0]   op;
    logic         zero, carry, ovf;
    int           checks = 0;
    int           errors = 0;

    always #10 clk = ~clk;

    alu_core #(.WIDTH(W)) i_alu_core (
        .a_i        (a),
        .b_i        (b),
        .op_i       (op),
        .result_o   (result),
        .zero_o     (zero),
        .carry_o    (carry),
        .overflow_o (ovf)
    );

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: a=%h b=%h op=%b actual=%h expected=%h",
                     req, what, a, b, op, act, exp);
        end
    endtask

    // Drive one vector, sample half a cycle later and check every output.
    task automatic apply(input logic [W-1:0] av, input logic [W-1:0] bv,
                         input logic [2:0] opv, input string req);
        logic [W:0]   s33, d33;
        logic [W-1:0] er;
        logic         ec, eo, arith;
        @(posedge clk);
        a = av; b = bv; op = opv;
        s33 = {1'b0, av} + {1'b0, bv};
        d33 = {1'b0, av} + {1'b0, ~bv} + 1;
        arith = 1'b1; ec = 1'b0; eo = 1'b0;
        case (opv)
            3'b000: begin er = av & bv; arith = 1'b0; end
            3'b001: begin er = av | bv; arith = 1'b0; end
            3'b010: begin
                er = s33[W-1:0]; ec = s33[W];
                eo = (av[W-1] == bv[W-1]) && (s33[W-1] != av[W-1]);
            end
            3'b110, 3'b111: begin
                er = (opv == 3'b110) ? d33[W-1:0]
                                     : (($signed(av) < $signed(bv)) ? 1 : 0);
                ec = (av >= bv);
                eo = (av[W-1] != bv[W-1]) && (d33[W-1] != av[W-1]);
            end
            default: begin er = '0; arith = 1'b0; end
        endcase
        @(negedge clk);
        check(req, "result", result, er);
        check("R6", "zero", {31'b0, zero}, {31'b0, (er == '0)});
        if (arith) begin
            check((opv == 3'b010) ? "R3" : "R9", "carry", {31'b0, carry}, {31'b0, ec});
            check("R7", "overflow", {31'b0, ovf}, {31'b0, eo});
        end
    endtask

    task automatic t_quiet_inputs;   // all-zero inputs, AND code: result 0, zero set
        apply('0, '0, 3'b000, "R1");
    endtask

    task automatic t_logic_ops;      // R1 and R2 patterns
        apply(32'hF0F0_A5A5, 32'h0FF0_FF00, 3'b000, "R1");
        apply(ALL_ONES, MOST_NEG, 3'b000, "R1");
        apply(32'hF0F0_A5A5, 32'h0FF0_FF00, 3'b001, "R2");
        apply('0, '0, 3'b001, "R2");
    endtask

    task automatic t_add_ops;        // R3 carry and R7 overflow edges
        apply(32'd1234, 32'd4321, 3'b010, "R3");
        apply(ALL_ONES, 32'd1, 3'b010, "R3");
        apply(MOST_POS, 32'd1, 3'b010, "R3");
        apply(MOST_NEG, MOST_NEG, 3'b010, "R3");
    endtask

    task automatic t_sub_ops;        // R4 difference, R9 borrow, equality via R6
        apply(32'd50, 32'd20, 3'b110, "R4");
        apply(32'd20, 32'd50, 3'b110, "R4");
        apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b110, "R4");
        apply(MOST_NEG, 32'd1, 3'b110, "R4");
        apply('0, MOST_NEG, 3'b110, "R4");
    endtask

    task automatic t_slt_ops;        // R5 including overflowing differences
        apply(32'd3, 32'd7, 3'b111, "R5");
        apply(32'd7, 32'd3, 3'b111, "R5");
        apply(32'd9, 32'd9, 3'b111, "R5");
        apply(MOST_NEG, MOST_POS, 3'b111, "R5");
        apply(MOST_POS, MOST_NEG, 3'b111, "R5");
        apply(ALL_ONES, 32'd0, 3'b111, "R5");
        apply(MOST_NEG, 32'd1, 3'b111, "R5");
    endtask

    task automatic t_undefined_codes; // R8
        apply(ALL_ONES, 32'h1234_5678, 3'b011, "R8");
        apply(ALL_ONES, 32'h1234_5678, 3'b100, "R8");
        apply(MOST_POS, MOST_NEG, 3'b101, "R8");
    endtask

    task automatic t_random;
        logic [2:0] codes [5] = '{3'b000, 3'b001, 3'b010, 3'b110, 3'b111};
        void'($urandom(32'h5EED));
        for (int n = 0; n < 400; n++) begin
            apply($urandom, $urandom, codes[n % 5], "R4");
        end
    endtask

    task automatic summary;
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        a = '0; b = '0; op = 3'b000;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        t_quiet_inputs();
        t_logic_ops();
        t_add_ops();
        t_sub_ops();
        t_slt_ops();
        t_undefined_codes();
        t_random();
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
        $finish;
    end
endmodule